// File: doc/BRIEF.md
# Binary Add/Subtract Status-Flag ALU

This block is the arithmetic slice of an 8-bit accumulator datapath. It takes the accumulator, an operand byte, a two-bit operation code and the processor's current status byte. On a cycle where the write strobe is high, it registers a result byte and a new status byte. It computes binary add-with-carry, subtract-with-borrow and a decrement of the operand. The carry, zero, overflow and negative bits are rebuilt by rule, and the other status bits are carried through.

Both outputs are registered. The surrounding sequencer presents the operands and pulses the strobe. It reads the result and status in the following cycle, writes the result back to the accumulator or to memory, and writes the status back to its flag register. The decimal bit is stored and passed along, but arithmetic stays binary whatever its value.

Top module: `flag_alu`

## Requirements
- R1: With op code 2'b00 (add), the result is the low byte of acc + operand + status bit 0 (carry). The new carry is 1 exactly when that 9-bit sum exceeds 0xFF.
- R2: On add, the new overflow (status bit 6) is bit 7 of (NOT(acc XOR operand)) AND (acc XOR result).
- R3: With op code 2'b01 (subtract), the result is the low byte of acc − operand − (1 − carry). The new carry is 1 exactly when no borrow occurred, that is, when the true difference is not negative.
- R4: On subtract, the new overflow is bit 7 of (acc XOR operand) AND (acc XOR result).
- R5: With op code 2'b10 or 2'b11 (decrement), the result is operand − 1 modulo 256. Carry (bit 0) and overflow (bit 6) are copied unchanged from the status input.
- R6: After every write, zero (bit 1) is 1 exactly when the result byte is 0x00, and negative (bit 7) equals bit 7 of the result byte.
- R7: Bits 2 (interrupt-disable), 3 (decimal) and 4 (break) are copied from the status input. A set decimal bit does not change the binary result or the flags.
- R8: Bit 5 of the status output always reads 1, even when bit 5 of the status input is 0.
- R9: While the write strobe is low, result and status outputs keep their values whatever the other inputs do.
- R10: Synchronous active-high reset sets the result to 0x00 and the status to 0x22 (reserved and zero set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_in | input | 8 | Accumulator value |
| opd_in | input | 8 | Operand byte |
| op_sel | input | 2 | 00 add, 01 subtract, 1x decrement |
| stat_in | input | 8 | Current status byte |
| wr_en | input | 1 | Register result and status this cycle |
| res_out | output | 8 | Registered result byte |
| stat_out | output | 8 | Registered status byte |

## Verification
Every register in this block faces a port, so a wrong carry, overflow or pass-through bit shows up on the status output in the cycle right after the strobe. It stays visible until the next strobe. A hold fault appears as a change on either output during strobe-low cycles. A mis-forced reserved bit, or a zero or negative flag that disagrees with the result byte, can be seen on any cycle after reset. The bench sweeps operand pairs for every operation with both carry values and compares against a model built from the requirements. It adds hand-computed signed-overflow, borrow and decimal-bit cases, and directed checks of reset and hold.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int STAT_W = 8;

  // status bit positions (a neighbouring sequencer decodes these)
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_D = 3;
  localparam int SB_B = 4;
  localparam int SB_R = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  localparam logic [STAT_W-1:0] STAT_RESET = 8'h22;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DECA = 2'b10,
    OP_DECB = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int XW = W + 1;

  logic [W-1:0]  b_eff;
  logic [XW-1:0] full;

  // subtract as a + ~b + carry: carry-out then means "no borrow"
  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = full[W-1:0];
    cout  = full[W];
    ovf   = ~(a[W-1] ^ b_eff[W-1]) & (a[W-1] ^ full[W-1]);
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int W = 8
) (
  input  logic [alu_pkg::STAT_W-1:0] stat_in,
  input  logic                        is_dec,
  input  logic [W-1:0]                res,
  input  logic                        cout,
  input  logic                        ovf,
  output logic [alu_pkg::STAT_W-1:0] stat_nxt
);
  import alu_pkg::*;

  // bits copied unchanged from the incoming status
  localparam logic [STAT_W-1:0] KEEP_MASK =
    (STAT_W'(1) << SB_I) | (STAT_W'(1) << SB_D) | (STAT_W'(1) << SB_B);

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_bit
      if (gi == SB_C) begin : g_c
        assign stat_nxt[gi] = is_dec ? stat_in[gi] : cout;
      end else if (gi == SB_V) begin : g_v
        assign stat_nxt[gi] = is_dec ? stat_in[gi] : ovf;
      end else if (gi == SB_Z) begin : g_z
        assign stat_nxt[gi] = (res == '0);
      end else if (gi == SB_N) begin : g_n
        assign stat_nxt[gi] = res[W-1];
      end else if (gi == SB_R) begin : g_r
        assign stat_nxt[gi] = 1'b1;
      end else if (KEEP_MASK[gi]) begin : g_keep
        assign stat_nxt[gi] = stat_in[gi];
      end else begin : g_zero
        assign stat_nxt[gi] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opd_in,
  input  logic [1:0]   op_sel,
  input  logic [7:0]   stat_in,
  input  logic         wr_en,
  output logic [W-1:0] res_out,
  output logic [7:0]   stat_out
);
  import alu_pkg::*;

  alu_op_e     op;
  logic        is_dec;
  logic        is_sub;
  logic [W-1:0] as_sum;
  logic        as_cout;
  logic        as_ovf;
  logic [W-1:0] dec_val;
  logic [W-1:0] res_nxt;
  logic [STAT_W-1:0] stat_nxt;
  logic [W-1:0] res_q;
  logic [STAT_W-1:0] stat_q;

  always_comb begin
    op      = alu_op_e'(op_sel);
    is_dec  = (op == OP_DECA) || (op == OP_DECB);
    is_sub  = (op == OP_SUB);
    dec_val = opd_in - W'(1);
    res_nxt = is_dec ? dec_val : as_sum;
  end

  alu_addsub #(.W(W)) u_addsub (
    .a    (acc_in),
    .b    (opd_in),
    .cin  (stat_in[SB_C]),
    .sub  (is_sub),
    .sum  (as_sum),
    .cout (as_cout),
    .ovf  (as_ovf)
  );

  alu_status #(.W(W)) u_status (
    .stat_in  (stat_in),
    .is_dec   (is_dec),
    .res      (res_nxt),
    .cout     (as_cout),
    .ovf      (as_ovf),
    .stat_nxt (stat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      stat_q <= STAT_RESET;
    end else if (wr_en) begin
      res_q  <= res_nxt;
      stat_q <= stat_nxt;
    end
  end

  assign res_out  = res_q;
  assign stat_out = stat_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opd_in,
  input logic [1:0]   op_sel,
  input logic [7:0]   stat_in,
  input logic         wr_en,
  input logic [W-1:0] res_out,
  input logic [7:0]   stat_out
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(res_out) && $stable(stat_out)));

  p_rsv_set_r8: assert property (@(posedge clk) disable iff (rst)
    stat_out[5] == 1'b1);

  p_zn_track_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_out[1] == (res_out == '0)) && (stat_out[7] == res_out[W-1]));

  p_dec_value_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_sel[1]) |=> (res_out == W'($past(opd_in) - W'(1))));

  p_dec_keep_cv_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_sel[1]) |=>
      (stat_out[0] == $past(stat_in[0]) && stat_out[6] == $past(stat_in[6])));

  p_pass_bits_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (stat_out[4:2] == $past(stat_in[4:2])));

  p_add_carry_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_sel == 2'b00) |=>
      (stat_out[0] == (({1'b0, $past(acc_in)} + {1'b0, $past(opd_in)}
                        + {{W{1'b0}}, $past(stat_in[0])}) > (W+1)'(255))));

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_sel == 2'b01 && stat_in[0]) |=>
      (stat_out[0] == ($past(acc_in) >= $past(opd_in))));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_in   (acc_in),
  .opd_in   (opd_in),
  .op_sel   (op_sel),
  .stat_in  (stat_in),
  .wr_en    (wr_en),
  .res_out  (res_out),
  .stat_out (stat_out)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_in = '0;
  logic [7:0] opd_in = '0;
  logic [1:0] op_sel = '0;
  logic [7:0] stat_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] res_out;
  logic [7:0] stat_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst(rst), .acc_in(acc_in), .opd_in(opd_in),
    .op_sel(op_sel), .stat_in(stat_in), .wr_en(wr_en),
    .res_out(res_out), .stat_out(stat_out)
  );

  // {op, acc, opd, stat_in, exp_res, exp_stat}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 8'h50, 8'h50, 8'h20, 8'hA0, 8'hE0},  // R2 signed overflow on add
    {2'b00, 8'hFF, 8'h01, 8'h20, 8'h00, 8'h23},  // R1 carry out, zero
    {2'b00, 8'h80, 8'h80, 8'h20, 8'h00, 8'h63},  // R2 negative+negative
    {2'b00, 8'h10, 8'h20, 8'h29, 8'h31, 8'h28},  // R7 decimal set, carry in
    {2'b01, 8'h50, 8'h10, 8'h21, 8'h40, 8'h21},  // R3 no borrow
    {2'b01, 8'h50, 8'h10, 8'h20, 8'h3F, 8'h21},  // R3 borrow in
    {2'b01, 8'h00, 8'h01, 8'h21, 8'hFF, 8'hA0},  // R3 borrow out
    {2'b01, 8'h80, 8'h01, 8'h21, 8'h7F, 8'h61},  // R4 overflow
    {2'b01, 8'h7F, 8'hFF, 8'h21, 8'h80, 8'hE0},  // R4 overflow, borrow
    {2'b10, 8'h00, 8'h01, 8'h61, 8'h00, 8'h63},  // R5 keeps C,V
    {2'b11, 8'h00, 8'h00, 8'h20, 8'hFF, 8'hA0},  // R5 wrap
    {2'b10, 8'h00, 8'h80, 8'hC3, 8'h7F, 8'h61},  // R8 reserved forced
    {2'b00, 8'h01, 8'h01, 8'h14, 8'h02, 8'h34},  // R7 I,B pass
    {2'b01, 8'h05, 8'h05, 8'h09, 8'h00, 8'h2B}   // R7 decimal ignored
  };

  function automatic logic [15:0] model(input logic [1:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] s);
    int t;
    logic [7:0] r;
    logic c, v;
    c = s[0];
    v = s[6];
    if (op == 2'b00) begin
      t = int'(a) + int'(b) + int'(s[0]);
      r = t[7:0];
      c = (t > 255);
      v = ((~(a ^ b)) & (a ^ r) & 8'h80) != 0;
    end else if (op == 2'b01) begin
      t = int'(a) - int'(b) - (1 - int'(s[0]));
      r = t[7:0];
      c = (t >= 0);
      v = ((a ^ b) & (a ^ r) & 8'h80) != 0;
    end else begin
      r = b - 8'd1;
    end
    return {r, r[7], v, 1'b1, s[4:2], (r == 8'h00), c};
  endfunction

  function automatic string tag(input logic [1:0] op);
    return (op == 2'b00) ? "R1/R2/R6" : (op == 2'b01) ? "R3/R4/R6" : "R5/R6";
  endfunction

  task automatic check(input string req, input logic [7:0] r, input logic [7:0] s,
                       input logic [7:0] er, input logic [7:0] es);
    n_vec++;
    if (r !== er || s !== es) begin
      n_fail++;
      $display("FAIL %s: res=%h stat=%h expected res=%h stat=%h", req, r, s, er, es);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] s);
    @(negedge clk);
    op_sel = op; acc_in = a; opd_in = b; stat_in = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    logic [7:0] hr, hs;
    logic [15:0] m;
    repeat (3) @(negedge clk);
    check("R10 reset", res_out, stat_out, 8'h00, 8'h22);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][41:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
      check(tag(VEC[i][41:40]), res_out, stat_out, VEC[i][15:8], VEC[i][7:0]);
    end

    // sweep against the model; the decimal bit is toggled too (R7)
    for (int op = 0; op < 3; op++) begin
      for (int a = 0; a < 256; a += 5) begin
        for (int b = 0; b < 256; b++) begin
          logic [7:0] s;
          s = {1'b0, b[1], 1'b1, 1'b0, b[2], 1'b0, 1'b0, a[0] ^ b[0]};
          apply(2'(op), 8'(a), 8'(b), s);
          m = model(2'(op), 8'(a), 8'(b), s);
          check(tag(2'(op)), res_out, stat_out, m[15:8], m[7:0]);
        end
      end
    end

    // R9: strobe low, inputs changing, outputs held
    apply(2'b00, 8'h7F, 8'h01, 8'h20);
    hr = res_out; hs = stat_out;
    check("R2 pre-hold", hr, hs, 8'h80, 8'hE0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_sel = 2'(k); acc_in = 8'(k * 37); opd_in = 8'(k * 91); stat_in = 8'hFF;
    end
    @(negedge clk);
    check("R9 hold", res_out, stat_out, hr, hs);

    // R10: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset mid-run", res_out, stat_out, 8'h00, 8'h22);
    rst = 1'b0;
    apply(2'b10, 8'h00, 8'h00, 8'h00);
    check("R8 reserved from zero status", res_out, stat_out, 8'hFF, 8'hA0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule